// File: doc/BRIEF.md
# Serial Control Word Receiver With Addressed Setting Registers

This block receives control words from a host microcontroller over a three-wire port: a serial data line, a shift clock and a request strobe. While the strobe is low, each rising edge of the shift clock captures one data bit, least significant bit first. A word is 12 bits. The low ten bits are the payload and the top two bits pick one of four 10-bit setting registers. When the host raises the strobe after exactly twelve clock edges, the word is committed to the register it addresses.

All three pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer before any edge is detected. All four registers load fixed defaults on reset. The block brings every setting field out as its own port and decodes the two attenuation trims and the delay volume code. It drives three active-low port bits as sink enables for open-collector drivers. After each accepted write it raises a one-cycle notice that carries the register address, so that logic further on (for example a mute sequencer that reacts to delay changes) can act on it.

Top module: `ser_ctrl_regs`

## Requirements
- R1: A word is shifted in LSB first. Bits 0-9 are the payload and bits 10-11 select the register. Only the addressed register changes, and only when the strobe rises after exactly 12 shift-clock rising edges.
- R2: If the strobe rises after any edge count other than 12 (fewer or more), the word is dropped. No register changes and no update notice is given.
- R3: Shift-clock edges that arrive while the strobe is high are ignored. A high strobe clears the edge count, so a partial word followed by a high strobe does not disturb the next full word.
- R4: After reset, registers 0, 1 and 2 hold all zeros. Register 3 holds delay code 3'b100, volume code 0000, and feedback, echo-line and mic-mix all 0.
- R5: Register 0 fields map to ports as follows: bit0 addSub, bit1 noiseOn, bits2-3 noiseCh, bits4-5 outSel, bits6-7 centerMode.
- R6: Register 1 fields map to ports as follows: bits0-1 surSrcSel, bits2-3 surOutSel, bit4 mixOn. Bits 5, 6 and 7 are port levels 1, 2 and 3, and loSink[i] is 1 (the driver pulls low) exactly when bit 5+i is 0.
- R7: Register 2 bits0-4 give centerAttenDb and bits5-9 give surroundAttenDb. Each is a binary dB attenuation from 0 to 31.
- R8: Register 3 fields are bits0-2 delaySel, bit7 feedbackOn, bit8 echoLine and bit9 micMix. The volume code is {bit3,bit4,bit5,bit6}, with bit3 as the MSB. Its step is 15 minus the code. Steps 0 to 10 give volGainDb of +3, 0, -2, -3, -4, -6, -8, -9, -10, -12 and -15. Steps 11 to 15 give volMute=1 with volGainDb=0.
- R9: Each accepted write raises updPulse for exactly one cycle, with updAddr equal to the written address. The pulse appears in the same cycle as the new register value, which is on the third clock edge after the strobe pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | Serial shift clock from host (asynchronous) |
| dataPin | input | 1 | Serial data from host (asynchronous) |
| reqPin | input | 1 | Request strobe; high blocks shifting, rising edge commits |
| addSub | output | 1 | Register 0 bit 0 |
| noiseOn | output | 1 | Register 0 bit 1 |
| noiseCh | output | 2 | Register 0 bits 2-3 |
| outSel | output | 2 | Register 0 bits 4-5 |
| centerMode | output | 2 | Register 0 bits 6-7 |
| surSrcSel | output | 2 | Register 1 bits 0-1 |
| surOutSel | output | 2 | Register 1 bits 2-3 |
| mixOn | output | 1 | Register 1 bit 4 |
| loSink | output | 3 | Sink enables for the three open-collector port bits |
| centerAttenDb | output | 5 | Center trim attenuation in dB |
| surroundAttenDb | output | 5 | Surround trim attenuation in dB |
| delaySel | output | 3 | Register 3 bits 0-2 |
| volGainDb | output | 5 | Signed delay volume gain in dB |
| volMute | output | 1 | Delay volume fully attenuated |
| feedbackOn | output | 1 | Register 3 bit 7 |
| echoLine | output | 1 | Register 3 bit 8 |
| micMix | output | 1 | Register 3 bit 9 |
| updPulse | output | 1 | One-cycle notice of an accepted write |
| updAddr | output | 2 | Address of the last accepted write |

## Verification
The assertions check on every cycle that the update notice follows each commit strobe exactly once and with the right address. They also check that no register moves without that notice, that registers other than the addressed one keep their value through a write, and that the trim outputs equal the committed payload. Whether the strobe is judged against the right bit count, whether clock edges during a high strobe are dropped, and whether the serial bits land LSB first can only be shown by the bench scenarios. Those scenarios cover short, long, interrupted and well-formed frames, checked against a cycle-accurate reference.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 2;
  localparam int WORD_W   = DATA_W + ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int TRIM_W   = 5;
  localparam int TRIM_REG = 2;
  localparam int VOL_REG  = 3;
  localparam int VOL_LSB  = 3;
  localparam int VOL_W    = 4;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_strobe_t;

  function automatic logic [DATA_W-1:0] resetValue(int idx);
    case (idx)
      3:       resetValue = DATA_W'(10'h004);
      default: resetValue = '0;
    endcase
  endfunction
endpackage

// File: rtl/ser_ctrl_sync.sv
module ser_ctrl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/ser_ctrl_frontend.sv
module ser_ctrl_frontend
  import ser_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckPin,
  input  logic       dataPin,
  input  logic       reqPin,
  output wr_strobe_t wrStb
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [2:0] pinsS;
  logic reqS, sckS, dataS;
  logic reqPrev, sckPrev;
  logic sckRise, reqRise;
  logic [WORD_W-1:0] shiftQ;
  logic [CNT_W-1:0]  bitCnt;

  ser_ctrl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({reqPin, sckPin, dataPin}),
    .syncOut (pinsS)
  );

  assign reqS    = pinsS[2];
  assign sckS    = pinsS[1];
  assign dataS   = pinsS[0];
  assign sckRise = sckS & ~sckPrev;
  assign reqRise = reqS & ~reqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      reqPrev <= 1'b0;
      shiftQ  <= '0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      reqPrev <= reqS;
      if (reqS) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shiftQ <= {dataS, shiftQ[WORD_W-1:1]};
        if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // A word commits only when the count is exactly one full word.
  always_comb begin
    wrStb.wrEn = reqRise && (bitCnt == CNT_W'(WORD_W));
    wrStb.addr = shiftQ[WORD_W-1 -: ADDR_W];
    wrStb.data = shiftQ[DATA_W-1:0];
  end
endmodule

// File: rtl/ser_ctrl_bank.sv
module ser_ctrl_bank
  import ser_ctrl_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  wr_strobe_t                        wrStb,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regQ,
  output logic                              updPulse,
  output logic [ADDR_W-1:0]                 updAddr,
  output logic [TRIM_W-1:0]                 centerAttenDb,
  output logic [TRIM_W-1:0]                 surroundAttenDb,
  output logic signed [4:0]                 volGainDb,
  output logic                              volMute
);
  logic [VOL_W-1:0] volCode;
  logic [VOL_W-1:0] volStep;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= resetValue(r);
      else if (wrStb.wrEn && wrStb.addr == ADDR_W'(r)) q <= wrStb.data;
    end
    assign regQ[r] = q;

    // R1: a write leaves every other register untouched
    a_r1_hold_others: assert property (@(posedge clk) disable iff (!rstN)
      (updPulse && updAddr != ADDR_W'(r)) |-> regQ[r] == $past(regQ[r]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updPulse <= 1'b0;
      updAddr  <= '0;
    end else begin
      updPulse <= wrStb.wrEn;
      if (wrStb.wrEn) updAddr <= wrStb.addr;
    end
  end

  assign centerAttenDb   = regQ[TRIM_REG][TRIM_W-1:0];
  assign surroundAttenDb = regQ[TRIM_REG][2*TRIM_W-1:TRIM_W];

  // Volume code is read with the lowest field bit as the MSB.
  always_comb begin
    for (int b = 0; b < VOL_W; b++) volCode[VOL_W-1-b] = regQ[VOL_REG][VOL_LSB+b];
    volStep = ~volCode;
    volMute = 1'b0;
    case (volStep)
      4'd0:    volGainDb = 5'sd3;
      4'd1:    volGainDb = 5'sd0;
      4'd2:    volGainDb = -5'sd2;
      4'd3:    volGainDb = -5'sd3;
      4'd4:    volGainDb = -5'sd4;
      4'd5:    volGainDb = -5'sd6;
      4'd6:    volGainDb = -5'sd8;
      4'd7:    volGainDb = -5'sd9;
      4'd8:    volGainDb = -5'sd10;
      4'd9:    volGainDb = -5'sd12;
      4'd10:   volGainDb = -5'sd15;
      default: begin volGainDb = 5'sd0; volMute = 1'b1; end
    endcase
  end

  // R9: every commit strobe yields the notice with its address
  a_r9_pulse_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.wrEn |=> (updPulse && updAddr == $past(wrStb.addr)));
  // R9: the notice lasts a single cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |=> !updPulse);
  // R2: registers never move without an accepted write
  a_r2_change_needs_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (regQ != $past(regQ)) |-> updPulse);
  // R7: trims follow the committed payload
  a_r7_trim_written: assert property (@(posedge clk) disable iff (!rstN)
    (updPulse && updAddr == ADDR_W'(TRIM_REG)) |->
      ({surroundAttenDb, centerAttenDb} == $past(wrStb.data)));
endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
  import ser_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckPin,
  input  logic              dataPin,
  input  logic              reqPin,
  output logic              addSub,
  output logic              noiseOn,
  output logic [1:0]        noiseCh,
  output logic [1:0]        outSel,
  output logic [1:0]        centerMode,
  output logic [1:0]        surSrcSel,
  output logic [1:0]        surOutSel,
  output logic              mixOn,
  output logic [2:0]        loSink,
  output logic [4:0]        centerAttenDb,
  output logic [4:0]        surroundAttenDb,
  output logic [2:0]        delaySel,
  output logic signed [4:0] volGainDb,
  output logic              volMute,
  output logic              feedbackOn,
  output logic              echoLine,
  output logic              micMix,
  output logic              updPulse,
  output logic [1:0]        updAddr
);
  wr_strobe_t wrStb;
  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;
  logic unusedSpare;

  ser_ctrl_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_frontend (
    .clk     (clk),
    .rstN    (rstN),
    .sckPin  (sckPin),
    .dataPin (dataPin),
    .reqPin  (reqPin),
    .wrStb   (wrStb)
  );

  ser_ctrl_bank u_bank (
    .clk             (clk),
    .rstN            (rstN),
    .wrStb           (wrStb),
    .regQ            (regQ),
    .updPulse        (updPulse),
    .updAddr         (updAddr),
    .centerAttenDb   (centerAttenDb),
    .surroundAttenDb (surroundAttenDb),
    .volGainDb       (volGainDb),
    .volMute         (volMute)
  );

  assign addSub      = regQ[0][0];
  assign noiseOn     = regQ[0][1];
  assign noiseCh     = regQ[0][3:2];
  assign outSel      = regQ[0][5:4];
  assign centerMode  = regQ[0][7:6];
  assign surSrcSel   = regQ[1][1:0];
  assign surOutSel   = regQ[1][3:2];
  assign mixOn       = regQ[1][4];
  assign loSink      = ~regQ[1][7:5];
  assign delaySel    = regQ[3][2:0];
  assign feedbackOn  = regQ[3][7];
  assign echoLine    = regQ[3][8];
  assign micMix      = regQ[3][9];
  assign unusedSpare = ^{regQ[0][9:8], regQ[1][9:8]};
endmodule

// File: tb/ser_ctrl_regs_bench.sv
module ser_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckPin = 1'b0, dataPin = 1'b0, reqPin = 1'b1;
  logic addSub, noiseOn, mixOn, volMute, feedbackOn, echoLine, micMix, updPulse;
  logic [1:0] noiseCh, outSel, centerMode, surSrcSel, surOutSel, updAddr;
  logic [2:0] loSink, delaySel;
  logic [4:0] centerAttenDb, surroundAttenDb;
  logic signed [4:0] volGainDb;

  int total = 0, bad = 0;
  int pulseCnt = 0;
  int lastAddr = 0;
  bit finished = 0;

  // reference model state
  logic [9:0] expReg [4];
  bit expPulse = 0;
  int expAddr = 0;
  bit modelLive = 0;
  logic [2:0] hist [4];
  bit bitsQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_ctrl_regs u_ser_ctrl_regs (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .dataPin(dataPin), .reqPin(reqPin),
    .addSub(addSub), .noiseOn(noiseOn), .noiseCh(noiseCh), .outSel(outSel),
    .centerMode(centerMode), .surSrcSel(surSrcSel), .surOutSel(surOutSel),
    .mixOn(mixOn), .loSink(loSink), .centerAttenDb(centerAttenDb),
    .surroundAttenDb(surroundAttenDb), .delaySel(delaySel), .volGainDb(volGainDb),
    .volMute(volMute), .feedbackOn(feedbackOn), .echoLine(echoLine),
    .micMix(micMix), .updPulse(updPulse), .updAddr(updAddr)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model: pins seen two edges late, then edge detection against the prior sample.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) hist[i] = 3'b000;
      expReg[0] = 10'h000; expReg[1] = 10'h000; expReg[2] = 10'h000; expReg[3] = 10'h004;
      expPulse = 0;
      bitsQ.delete();
      modelLive = 1;
    end else begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
      hist[0] = {reqPin, sckPin, dataPin};
      expPulse = 0;
      if (hist[2][2] && !hist[3][2] && bitsQ.size() == 12) begin
        logic [11:0] w;
        for (int i = 0; i < 12; i++) w[i] = bitsQ[i];
        expReg[w[11:10]] = w[9:0];
        expPulse = 1;
        expAddr = w[11:10];
      end
      if (hist[2][2]) bitsQ.delete();
      else if (hist[2][1] && !hist[3][1]) bitsQ.push_back(hist[2][0]);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && modelLive && !finished) begin
      chk("R5 reg0 fields", {centerMode, outSel, noiseCh, noiseOn, addSub}, expReg[0][7:0]);
      chk("R6 reg1 fields", {~loSink, mixOn, surOutSel, surSrcSel}, expReg[1][7:0]);
      chk("R7 reg2 fields", {surroundAttenDb, centerAttenDb}, expReg[2]);
      chk("R8 reg3 fields", {micMix, echoLine, feedbackOn, delaySel},
          {expReg[3][9:7], expReg[3][2:0]});
      chk("R9 pulse timing", updPulse, expPulse);
      if (expPulse) chk("R9 pulse address", updAddr, expAddr);
      if (updPulse) begin pulseCnt++; lastAddr = updAddr; end
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(logic [15:0] w, int nbits);
    @(negedge clk); reqPin = 1'b0;
    waitClk(4);
    for (int i = 0; i < nbits; i++) begin
      dataPin = w[i];
      waitClk(4); sckPin = 1'b1;
      waitClk(4); sckPin = 1'b0;
    end
    waitClk(4); reqPin = 1'b1;
    waitClk(12);
  endtask

  task automatic sendWord(int addr, int data);
    sendBits(16'((addr << 10) | data), 12);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(5);
    // R4 reset state
    chk("R4 reg0 default", {centerMode, outSel, noiseCh, noiseOn, addSub}, 0);
    chk("R4 lo sink default (R6)", loSink, 3'b111);
    chk("R4 trims default", {surroundAttenDb, centerAttenDb}, 0);
    chk("R4 delay default", delaySel, 3'b100);
    chk("R4 volume muted (R8)", volMute, 1);
    chk("R4 switches off", {micMix, echoLine, feedbackOn, mixOn}, 0);

    // R5 register 0
    sendWord(0, 10'h0B6);
    chk("R5 addSub", addSub, 0);
    chk("R5 noiseOn", noiseOn, 1);
    chk("R5 noiseCh", noiseCh, 1);
    chk("R5 outSel", outSel, 3);
    chk("R5 centerMode", centerMode, 2);

    // R6 register 1
    sendWord(1, 10'h0A9);
    chk("R6 surSrcSel", surSrcSel, 1);
    chk("R6 surOutSel", surOutSel, 2);
    chk("R6 mixOn", mixOn, 0);
    chk("R6 loSink", loSink, 3'b010);

    // R7 register 2
    sendWord(2, 10'h0F3);
    chk("R7 center 19", centerAttenDb, 19);
    chk("R7 surround 7", surroundAttenDb, 7);
    chk("R1 reg0 untouched", {centerMode, outSel, noiseCh, noiseOn, addSub}, 8'hB6);
    sendWord(2, 10'h3FF);
    chk("R7 center max", centerAttenDb, 31);
    chk("R7 surround max", surroundAttenDb, 31);

    // R8 register 3
    sendWord(3, 10'h2FA);
    chk("R8 delaySel", delaySel, 2);
    chk("R8 vol +3", int'(volGainDb), 3);
    chk("R8 not muted", volMute, 0);
    chk("R8 switches", {micMix, echoLine, feedbackOn}, 3'b101);
    sendWord(3, 10'h130);
    chk("R8 vol -12", int'(volGainDb), -12);
    chk("R8 echoLine", echoLine, 1);
    pulseCnt = 0;
    sendWord(3, 10'h010);
    chk("R8 step 11 mutes", volMute, 1);
    chk("R8 muted gain", int'(volGainDb), 0);
    chk("R9 one pulse per write", pulseCnt, 1);
    chk("R9 pulse address", lastAddr, 3);

    // R2 bad counts
    pulseCnt = 0;
    sendBits(16'((2 << 10) | 10'h000), 11);
    chk("R2 short frame dropped", centerAttenDb, 31);
    sendBits(16'h1000 | 16'((2 << 10) | 10'h000), 13);
    chk("R2 long frame dropped", surroundAttenDb, 31);
    chk("R2 no pulse", pulseCnt, 0);

    // R3 edges with strobe high
    sendBits(16'h0FFF, 7);
    dataPin = 1'b1;
    for (int i = 0; i < 5; i++) begin
      waitClk(4); sckPin = 1'b1;
      waitClk(4); sckPin = 1'b0;
    end
    chk("R3 partial and idle edges", pulseCnt, 0);
    sendWord(2, 10'h0A5);
    chk("R3 center after idle edges", centerAttenDb, 5);
    chk("R3 surround after idle edges", surroundAttenDb, 5);
    chk("R1 reg1 untouched", {~loSink, mixOn, surOutSel, surSrcSel}, 8'hA9);

    waitClk(5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule